// File: doc/BRIEF.md
# Transient Result Writeback Filter

This block sits beside the register file of a pipelined core. For every result that reaches writeback it decides whether the register-file write is needed. A write can be dropped when the value was short-lived and was seen only through the bypass network. The core reports four kinds of event to it, each as a single-cycle pulse carrying register indices:

- writebacks
- branches
- operand reads at issue, with a flag that says whether the read came from bypass and a flag that says whether the reader can be replayed
- destination definitions at issue

The block keeps one 3-bit tracking code per architectural register. In the same cycle as each writeback it raises `wb_drop` when that write may be skipped. When nothing proves that the write can be skipped, the write goes ahead.

Per register, the block follows the oldest value still in flight, plus at most one newer value that redefines it. The pipeline is expected to stall a third definition of a register while two values for it are still in flight. If a third definition does arrive, the block falls back to writing.

The whole tracking table can be copied into a shadow snapshot. It can later be restored from that snapshot so that the state can be recovered after an interrupt.

Top module: `trwf_filter`

## Requirements
- R1: After reset every register is untracked, and a writeback to any register gives `wb_drop` = 0.
- R2: `wb_drop` = 1 for a writeback whose value meets all of the following:
  - it had exactly one reader;
  - that reader had `iss_byp` = 1 and `iss_spec` = 0;
  - the register was redefined before this writeback;
  - no branch came between the value's definition and the redefinition.
- R3: A value that had no reader before it was redefined is written (`wb_drop` = 0).
- R4: A value read twice is written. This includes one instruction that names the register in both of its source slots.
- R5: A value whose reader had `iss_byp` = 0 (it read the register file, not bypass) is written.
- R6: A value whose reader had `iss_spec` = 1 (it may be replayed) is written.
- R7: A branch between a value's definition and its redefinition forces that value to be written. A branch after the redefinition leaves the older value's verdict unchanged.
- R8: A value not redefined before its writeback is written. A writeback to a register with nothing in flight is written.
- R9: Once the older value writes back, the newer value is tracked on its own. While the older value is still in flight, any read of the register, or any branch, forces the newer value to be written.
- R10: `ckpt_save` copies the whole table into the snapshot. `ckpt_restore` loads the table from the snapshot and discards every other event of that cycle. When both pulse together, the table takes the old snapshot and the snapshot takes the old table.
- R11: Events of one cycle apply in this order: writeback, branch, source 0 read, source 1 read, destination definition.
- R12: `wb_drop` is valid in the same cycle as `wb_vld`, and is 0 whenever `wb_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| wb_vld | input | 1 | A result writes back this cycle |
| wb_reg | input | 5 | Register written back |
| wb_drop | output | 1 | The write may be skipped |
| br_vld | input | 1 | A branch issues this cycle |
| iss_vld | input | 1 | An instruction issues this cycle |
| iss_src0_vld | input | 1 | Source 0 is used |
| iss_src0_reg | input | 5 | Source 0 register |
| iss_src0_byp | input | 1 | Source 0 read from bypass |
| iss_src1_vld | input | 1 | Source 1 is used |
| iss_src1_reg | input | 5 | Source 1 register |
| iss_src1_byp | input | 1 | Source 1 read from bypass |
| iss_spec | input | 1 | The issuing instruction may be replayed |
| iss_dst_vld | input | 1 | The instruction defines a destination |
| iss_dst_reg | input | 5 | Destination register |
| ckpt_save | input | 1 | Copy the table into the snapshot |
| ckpt_restore | input | 1 | Load the table from the snapshot |

## Verification
The assertions check four things on every cycle:

- the table is clean when reset lifts;
- no single-reader or proven state survives a branch;
- a restore reproduces the snapshot exactly;
- a writeback to an untracked register is never dropped.

The per-value verdict depends on a history of events across many cycles: the count and kind of readers, where redefinition falls against branches, and the hand-over from the older to the newer value. Only the bench's scenarios can show it. Those scenarios use directed sequences and a long constrained-random run checked against a queue-based model.

// File: rtl/trwf_pkg.sv
package trwf_pkg;

  // Tracking code per register: older value in flight, and newer value after a redefinition
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,  // nothing in flight
    ST_FRESH     = 3'd1,  // one value, no reader yet
    ST_ONE       = 3'd2,  // one value, one clean bypass reader
    ST_SPENT     = 3'd3,  // one value, must be written
    ST_HELD_OK   = 3'd4,  // redefined: older droppable, newer clean
    ST_HELD_WB   = 3'd5,  // redefined: older written, newer clean
    ST_HELD_OK_X = 3'd6,  // redefined: older droppable, newer must write
    ST_HELD_WB_X = 3'd7   // redefined: older written, newer must write
  } trk_t;

  function automatic trk_t on_wb(trk_t s);
    case (s)
      ST_HELD_OK, ST_HELD_WB:     on_wb = ST_FRESH;
      ST_HELD_OK_X, ST_HELD_WB_X: on_wb = ST_SPENT;
      default:                    on_wb = ST_IDLE;
    endcase
  endfunction

  function automatic trk_t on_branch(trk_t s);
    case (s)
      ST_FRESH, ST_ONE: on_branch = ST_SPENT;
      ST_HELD_OK:       on_branch = ST_HELD_OK_X;
      ST_HELD_WB:       on_branch = ST_HELD_WB_X;
      default:          on_branch = s;
    endcase
  endfunction

  function automatic trk_t on_read(trk_t s, logic clean);
    case (s)
      ST_FRESH:   on_read = clean ? ST_ONE : ST_SPENT;
      ST_ONE:     on_read = ST_SPENT;
      ST_HELD_OK: on_read = ST_HELD_OK_X;
      ST_HELD_WB: on_read = ST_HELD_WB_X;
      default:    on_read = s;
    endcase
  endfunction

  function automatic trk_t on_def(trk_t s);
    case (s)
      ST_IDLE:            on_def = ST_FRESH;
      ST_ONE:             on_def = ST_HELD_OK;
      ST_FRESH, ST_SPENT: on_def = ST_HELD_WB;
      default:            on_def = ST_HELD_WB_X;  // third value in flight: write everything
    endcase
  endfunction

  function automatic logic may_drop(trk_t s);
    may_drop = (s == ST_HELD_OK) || (s == ST_HELD_OK_X);
  endfunction

endpackage

// File: rtl/trwf_slot.sv
module trwf_slot
  import trwf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wb_hit,
  input  logic br_hit,
  input  logic rd0_hit,
  input  logic rd0_clean,
  input  logic rd1_hit,
  input  logic rd1_clean,
  input  logic def_hit,
  input  logic rest_hit,
  input  trk_t rest_val,
  output trk_t st
);

  trk_t s_wb, s_br, s_rd0, s_rd1, s_def, st_nxt;
  logic upd_en;

  // Fixed order within a cycle: writeback, branch, source 0, source 1, definition
  always_comb begin
    s_wb   = wb_hit  ? on_wb(st)                  : st;
    s_br   = br_hit  ? on_branch(s_wb)            : s_wb;
    s_rd0  = rd0_hit ? on_read(s_br, rd0_clean)   : s_br;
    s_rd1  = rd1_hit ? on_read(s_rd0, rd1_clean)  : s_rd0;
    s_def  = def_hit ? on_def(s_rd1)              : s_rd1;
    st_nxt = rest_hit ? rest_val : s_def;
    upd_en = rest_hit | wb_hit | br_hit | rd0_hit | rd1_hit | def_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st <= ST_IDLE;
    else if (upd_en) st <= st_nxt;
  end

endmodule

// File: rtl/trwf_snap.sv
module trwf_snap
  import trwf_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic save,
  input  trk_t live [NREG],
  output trk_t shadow [NREG]
);

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    shadow[g] <= ST_IDLE;
      else if (save) shadow[g] <= live[g];
    end
  end

endmodule

// File: rtl/trwf_filter.sv
module trwf_filter
  import trwf_pkg::*;
#(
  parameter  int NREG = 32,
  localparam int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_vld,
  input  logic [IW-1:0] wb_reg,
  output logic          wb_drop,
  input  logic          br_vld,
  input  logic          iss_vld,
  input  logic          iss_src0_vld,
  input  logic [IW-1:0] iss_src0_reg,
  input  logic          iss_src0_byp,
  input  logic          iss_src1_vld,
  input  logic [IW-1:0] iss_src1_reg,
  input  logic          iss_src1_byp,
  input  logic          iss_spec,
  input  logic          iss_dst_vld,
  input  logic [IW-1:0] iss_dst_reg,
  input  logic          ckpt_save,
  input  logic          ckpt_restore
);

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  trk_t tbl  [NREG];
  trk_t snap [NREG];

  logic clean0, clean1;
  assign clean0 = iss_src0_byp & ~iss_spec;
  assign clean1 = iss_src1_byp & ~iss_spec;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic wb_hit, rd0_hit, rd1_hit, def_hit;
    assign wb_hit  = wb_vld && (wb_reg == IW'(g));
    assign rd0_hit = iss_vld && iss_src0_vld && (iss_src0_reg == IW'(g));
    assign rd1_hit = iss_vld && iss_src1_vld && (iss_src1_reg == IW'(g));
    assign def_hit = iss_vld && iss_dst_vld  && (iss_dst_reg  == IW'(g));

    trwf_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_q),
      .wb_hit    (wb_hit),
      .br_hit    (br_vld),
      .rd0_hit   (rd0_hit),
      .rd0_clean (clean0),
      .rd1_hit   (rd1_hit),
      .rd1_clean (clean1),
      .def_hit   (def_hit),
      .rest_hit  (ckpt_restore),
      .rest_val  (snap[g]),
      .st        (tbl[g])
    );
  end

  trwf_snap #(.NREG(NREG)) u_snap (
    .clk    (clk),
    .rst_n  (rst_q),
    .save   (ckpt_save),
    .live   (tbl),
    .shadow (snap)
  );

  // Verdict taken from the table state before this cycle's events
  always_comb begin
    wb_drop = 1'b0;
    if (wb_vld) wb_drop = may_drop(tbl[wb_reg]);
  end

endmodule

// File: rtl/trwf_chk.sv
module trwf_chk
  import trwf_pkg::*;
#(
  parameter  int NREG = 32,
  localparam int IW   = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_q,
  input logic          wb_vld,
  input logic [IW-1:0] wb_reg,
  input logic          wb_drop,
  input logic          br_vld,
  input logic          ckpt_restore,
  input trk_t          tbl  [NREG],
  input trk_t          snap [NREG]
);

  logic [NREG*3-1:0] tbl_v, snap_v;
  logic all_idle, any_single;

  always_comb begin
    all_idle   = 1'b1;
    any_single = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      tbl_v[i*3 +: 3]  = tbl[i];
      snap_v[i*3 +: 3] = snap[i];
      if (tbl[i] != ST_IDLE) all_idle = 1'b0;
      if (tbl[i] == ST_ONE || tbl[i] == ST_HELD_OK) any_single = 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> all_idle);

  // R7
  branch_clears_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (br_vld && !ckpt_restore) |=> !any_single);

  // R10
  restore_copy_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ckpt_restore |=> (tbl_v == $past(snap_v)));

  // R8
  idle_wb_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wb_vld && tbl[wb_reg] == ST_IDLE) |-> !wb_drop);

endmodule

bind trwf_filter trwf_chk #(.NREG(NREG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_q        (rst_q),
  .wb_vld       (wb_vld),
  .wb_reg       (wb_reg),
  .wb_drop      (wb_drop),
  .br_vld       (br_vld),
  .ckpt_restore (ckpt_restore),
  .tbl          (tbl),
  .snap         (snap)
);

// File: tb/sim_trwf_filter.sv
`timescale 1ns/1ps
module sim_trwf_filter;

  localparam int NREG = 32;
  localparam int IW   = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic wb_vld, br_vld, iss_vld, s0v, s0b, s1v, s1b, spec, dv, sv, rs;
  logic [IW-1:0] wb_reg, s0r, s1r, dr;
  logic wb_drop;

  trwf_filter #(.NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wb_vld(wb_vld), .wb_reg(wb_reg), .wb_drop(wb_drop),
    .br_vld(br_vld), .iss_vld(iss_vld),
    .iss_src0_vld(s0v), .iss_src0_reg(s0r), .iss_src0_byp(s0b),
    .iss_src1_vld(s1v), .iss_src1_reg(s1r), .iss_src1_byp(s1b),
    .iss_spec(spec), .iss_dst_vld(dv), .iss_dst_reg(dr),
    .ckpt_save(sv), .ckpt_restore(rs)
  );

  // Reference model: per register a queue of in-flight values
  typedef struct {
    int uses;
    bit bad;
    bit redefd;
  } mv_t;

  mv_t mq [NREG][$];
  mv_t ms [NREG][$];

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  task automatic chk(input bit got, input bit want, input string tag);
    nchk++;
    if (got !== want) begin
      nerr++;
      $display("FAIL %s: wb_drop got=%0b exp=%0b at %0t", tag, got, want, $time);
    end
  endtask

  task automatic clr();
    wb_vld = 0; wb_reg = '0; br_vld = 0; iss_vld = 0;
    s0v = 0; s0r = '0; s0b = 0; s1v = 0; s1r = '0; s1b = 0;
    spec = 0; dv = 0; dr = '0; sv = 0; rs = 0;
  endtask

  function automatic bit model_drop(int r);
    mv_t v;
    if (mq[r].size() == 0) return 0;
    v = mq[r][0];
    return v.redefd && !v.bad && (v.uses == 1);
  endfunction

  task automatic model_read(int r, bit clean);
    int n;
    n = mq[r].size();
    if (n == 0) return;
    if (n >= 2) mq[r][n-1].bad = 1;
    else begin
      mq[r][0].uses++;
      if (!clean || mq[r][0].uses > 1) mq[r][0].bad = 1;
    end
  endtask

  task automatic model_step();
    mv_t nv;
    if (rs) begin
      for (int i = 0; i < NREG; i++) begin
        mv_t tmp [$];
        tmp = mq[i];
        mq[i] = ms[i];
        if (sv) ms[i] = tmp;
      end
      return;
    end
    if (sv) for (int i = 0; i < NREG; i++) ms[i] = mq[i];
    if (wb_vld && mq[wb_reg].size() > 0) void'(mq[wb_reg].pop_front());
    if (br_vld)
      for (int i = 0; i < NREG; i++)
        for (int k = 0; k < mq[i].size(); k++)
          if (!mq[i][k].redefd) mq[i][k].bad = 1;
    if (iss_vld && s0v) model_read(int'(s0r), s0b && !spec);
    if (iss_vld && s1v) model_read(int'(s1r), s1b && !spec);
    if (iss_vld && dv) begin
      if (mq[dr].size() > 0) mq[dr][mq[dr].size()-1].redefd = 1;
      nv.uses = 0; nv.bad = 0; nv.redefd = 0;
      mq[dr].push_back(nv);
    end
  endtask

  // Called just after a falling edge with inputs set; exp < 0 means use the model
  task automatic go(input int exp, input string tag);
    bit want;
    #1;
    if (wb_vld) begin
      want = (exp >= 0) ? bit'(exp) : model_drop(int'(wb_reg));
      chk(wb_drop, want, tag);
    end else begin
      chk(wb_drop, 1'b0, "R12 no writeback");
    end
    model_step();
    @(negedge clk);
    clr();
  endtask

  task automatic t_def(int r);
    clr(); iss_vld = 1; dv = 1; dr = IW'(r); go(-1, "def");
  endtask

  task automatic t_use(int r, bit byp, bit sp);
    clr(); iss_vld = 1; s0v = 1; s0r = IW'(r); s0b = byp; spec = sp; go(-1, "use");
  endtask

  task automatic t_wb(int r, int exp, string tag);
    clr(); wb_vld = 1; wb_reg = IW'(r); go(exp, tag);
  endtask

  task automatic t_br();
    clr(); br_vld = 1; go(-1, "branch");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: nothing tracked after reset
    t_wb(0, 0, "R1 reset reg0");
    t_wb(31, 0, "R1 reset reg31");

    // R2: one clean bypass reader, then redefinition
    t_def(3); t_use(3, 1, 0); t_def(3);
    t_wb(3, 1, "R2 transient dropped");
    t_wb(3, 0, "R8 newer not redefined");

    // R3: no reader
    t_def(4); t_def(4);
    t_wb(4, 0, "R3 no reader"); t_wb(4, 0, "R8 newer");

    // R4: two readers, and both sources in one instruction
    t_def(5); t_use(5, 1, 0); t_use(5, 1, 0); t_def(5);
    t_wb(5, 0, "R4 two reads"); t_wb(5, 0, "R8 newer");
    t_def(6);
    clr(); iss_vld = 1; s0v = 1; s0r = 6; s0b = 1; s1v = 1; s1r = 6; s1b = 1; go(-1, "dual read");
    t_def(6);
    t_wb(6, 0, "R4 both sources"); t_wb(6, 0, "R8 newer");

    // R5: reader took the register file path
    t_def(7); t_use(7, 0, 0); t_def(7);
    t_wb(7, 0, "R5 non-bypass read"); t_wb(7, 0, "R8 newer");

    // R6: replay-exposed reader
    t_def(8); t_use(8, 1, 1); t_def(8);
    t_wb(8, 0, "R6 replayable reader"); t_wb(8, 0, "R8 newer");

    // R7: branch before and after the redefinition
    t_def(9); t_use(9, 1, 0); t_br(); t_def(9);
    t_wb(9, 0, "R7 branch between"); t_wb(9, 0, "R8 newer");
    t_def(10); t_use(10, 1, 0); t_def(10); t_br();
    t_wb(10, 1, "R7 branch after redefinition"); t_wb(10, 0, "R9 newer after branch");

    // R8: never redefined; stray writeback
    t_def(11); t_use(11, 1, 0);
    t_wb(11, 0, "R8 not redefined");
    t_wb(12, 0, "R8 nothing in flight");

    // R9: newer value tracking
    t_def(13); t_use(13, 1, 0); t_def(13); t_use(13, 1, 0);
    t_wb(13, 1, "R9 older still dropped"); t_def(13);
    t_wb(13, 0, "R9 newer read early"); t_wb(13, 0, "R8 last");
    t_def(14); t_use(14, 1, 0); t_def(14);
    t_wb(14, 1, "R9 first");
    t_use(14, 1, 0); t_def(14);
    t_wb(14, 1, "R9 newer tracked after hand-over"); t_wb(14, 0, "R8 last");

    // R11: same-cycle ordering
    t_def(15);
    clr(); iss_vld = 1; s0v = 1; s0r = 15; s0b = 1; dv = 1; dr = 15; go(-1, "read+def");
    t_wb(15, 1, "R11 read before def"); t_wb(15, 0, "R8 newer");
    t_def(16); t_use(16, 1, 0);
    clr(); wb_vld = 1; wb_reg = 16; iss_vld = 1; dv = 1; dr = 16; go(0, "R11 writeback before def");
    t_use(16, 1, 0); t_def(16);
    t_wb(16, 1, "R11 fresh after same-cycle def"); t_wb(16, 0, "R8 newer");
    t_def(17); t_use(17, 1, 0);
    clr(); br_vld = 1; iss_vld = 1; dv = 1; dr = 17; go(-1, "br+def");
    t_wb(17, 0, "R11 branch before def"); t_wb(17, 0, "R8 newer");

    // R10: checkpoint and restore
    t_def(20); t_use(20, 1, 0);
    clr(); sv = 1; go(-1, "save");
    t_def(20);
    t_wb(20, 1, "R10 before restore");
    clr(); rs = 1; iss_vld = 1; s0v = 1; s0r = 20; s0b = 1; go(-1, "restore with read");
    t_def(20);
    t_wb(20, 1, "R10 restored single reader, read ignored");
    t_wb(20, 0, "R10 newer");
    t_def(21); t_use(21, 1, 0);
    clr(); sv = 1; rs = 1; go(-1, "save+restore");
    t_wb(21, 0, "R10 swap restored empty");
    clr(); rs = 1; go(-1, "restore swapped");
    t_def(21);
    t_wb(21, 1, "R10 swapped-in table");
    t_wb(21, 0, "R10 newer");

    // Constrained random run against the model
    for (int n = 0; n < 4000; n++) begin
      int pend;
      clr();
      if ($urandom_range(0, 2) == 0) begin wb_vld = 1; wb_reg = IW'($urandom_range(0, 7)); end
      if ($urandom_range(0, 11) == 0) br_vld = 1;
      if ($urandom_range(0, 1) == 0) begin
        iss_vld = 1;
        s0v = $urandom_range(0, 1); s0r = IW'($urandom_range(0, 7)); s0b = ($urandom_range(0, 4) != 0);
        s1v = ($urandom_range(0, 3) == 0); s1r = IW'($urandom_range(0, 7)); s1b = ($urandom_range(0, 4) != 0);
        spec = ($urandom_range(0, 7) == 0);
        dr = IW'($urandom_range(0, 7));
        pend = mq[dr].size();
        if (wb_vld && wb_reg == dr && pend > 0) pend--;
        dv = ($urandom_range(0, 1) == 0) && (pend < 2);
      end
      if ($urandom_range(0, 59) == 0) sv = 1;
      if ($urandom_range(0, 89) == 0) rs = 1;
      go(-1, "R2 R11 random verdict");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule